// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the software-visible control store of a PCI host bridge. A 32-bit register bus (address, write strobe, write data, combinational read data) reaches four groups of storage: a small window of address-translation words, a window of bus control words, eight interrupt mapping words and one reset control word. Decoding looks only at the low 16 bits of the address. Any offset outside the listed windows reads as zero and ignores writes.

Two outputs leave the block. `irq_map_en` carries the enable bit of each interrupt mapping word to a separate interrupt router. `soft_rst_req` is a one-cycle pulse that asks the system for a reset when software writes one of the two software trigger bits. The block has two resets. `pwr_rst_n` is power-on reset and clears everything. `sys_rst_n` is the ordinary system reset: it disables all interrupt mappings and leaves the general storage alone. The reset control word reports power-on status only on the first system reset after power-up, or after software has re-armed that history with a software power-on trigger.

Top module: `hbr_ctl_regs`

## Requirements
- R1: Offsets 0x0200, 0x0204 and 0x0208 are three read/write translation words, indexed by address bits [3:2]. Offset 0x020C reads zero and ignores writes.
- R2: Offsets 0x2000 to 0x202C are twelve read/write bus control words, indexed by address bits [5:2]. Offset 0x2030 reads zero.
- R3: Interrupt mapping word i is reached at offset 0x0C00 + 8*i + 4, for i from 0 to 7. An access in that window with address bit 2 clear reads zero and writes nothing.
- R4: A write to a mapping word updates only bit 31, its enable. Bits [30:0] keep their value. `irq_map_en[i]` equals bit 31 of word i.
- R5: After power-on reset, mapping word i reads 0x7C0 | (i << 2), with bits [10:6] = 0x1F and bits [4:2] = i. A system reset clears bit 31 of all eight words and changes no other bit.
- R6: The reset control word is at offset 0xF024. Offset 0xF020 reads zero and ignores writes. Write data is first masked to bits [31:27].
- R7: In the reset control word, bits 31, 28 and 27 clear when written with one and are unchanged when written with zero. Bits 30 and 29 take the written value.
- R8: A reset control write with bit 30 or bit 29 set drives `soft_rst_req` high for exactly the one cycle after the write edge. Any other write leaves it low.
- R9: After power-on reset, the reset control word reads 0x80000000. A later system reset sets it to 0x80000000 only if a write with bit 30 set came after the last such reset. A write with only bit 29 set does not re-arm it.
- R10: Offsets outside the listed windows (for example 0x0030, 0x5000, 0xF000) read zero and ignore writes. Address bits above bit 15 take no part in decoding.
- R11: Translation and control words keep their values through a system reset. Power-on reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| reg_addr | input | ADDR_W | Register bus byte address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_map_en | output | N_IMAP | Enable bit of each interrupt mapping word |
| soft_rst_req | output | 1 | One-cycle software reset request |

## Verification
A wrong stored bit shows up on `reg_rdata` in the same cycle as any read of the affected offset. A lost or stuck mapping enable shows up on `irq_map_en` one edge after the write or the reset that caused it. A bad power-on history does not appear at the moment it goes wrong. It shows only after the next system reset, as a wrong value in the reset control word, so the tests always follow a trigger write with a system reset before reading back. A misplaced or repeated reset request is visible on `soft_rst_req` in the cycle after the write edge and in the cycle after that.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_XLT  = 3'd1,
      RG_CTL  = 3'd2,
      RG_IMAP = 3'd3,
      RG_RST  = 3'd4
   } hbr_region_e;

   localparam logic [31:0] RC_PWR_ON  = 32'h8000_0000;
   localparam logic [31:0] RC_SW_PWR  = 32'h4000_0000;
   localparam logic [31:0] RC_SW_XINT = 32'h2000_0000;
   localparam logic [31:0] RC_KEEP    = 32'hF800_0000;
   localparam logic [31:0] RC_W1C     = 32'h9800_0000;
   localparam logic [31:0] RC_WDIR    = 32'h6000_0000;

   localparam logic [31:0] IMAP_ENABLE = 32'h8000_0000;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
#(
   parameter logic [15:0] XLT_BASE   = 16'h0200,
   parameter int          XLT_BYTES  = 12,
   parameter logic [15:0] CTL_BASE   = 16'h2000,
   parameter int          CTL_BYTES  = 48,
   parameter logic [15:0] IMAP_BASE  = 16'h0C00,
   parameter int          N_IMAP     = 8,
   parameter logic [15:0] RST_BASE   = 16'hF020
) (
   input  logic [15:0]  addr,
   output hbr_region_e  region,
   output logic [7:0]   idx
);
   localparam int IMAP_BYTES = N_IMAP * 8;

   logic [15:0] off_x, off_c, off_i, off_r;
   logic        hit_x, hit_c, hit_i, hit_r;

   always_comb begin
      off_x = addr - XLT_BASE;
      off_c = addr - CTL_BASE;
      off_i = addr - IMAP_BASE;
      off_r = addr - RST_BASE;
      hit_x = (addr >= XLT_BASE)  && ({16'd0, off_x} < 32'(XLT_BYTES));
      hit_c = (addr >= CTL_BASE)  && ({16'd0, off_c} < 32'(CTL_BYTES));
      hit_i = (addr >= IMAP_BASE) && ({16'd0, off_i} < 32'(IMAP_BYTES)) && addr[2];
      hit_r = (addr >= RST_BASE)  && (off_r < 16'd8) && addr[2];
      region = RG_NONE;
      idx    = 8'd0;
      if (hit_x) begin
         region = RG_XLT;
         idx    = off_x[9:2];
      end else if (hit_c) begin
         region = RG_CTL;
         idx    = off_c[9:2];
      end else if (hit_i) begin
         region = RG_IMAP;
         idx    = off_i[10:3];
      end else if (hit_r) begin
         region = RG_RST;
      end
   end
endmodule

// File: rtl/hbr_word_bank.sv
module hbr_word_bank #(
   parameter int N_WORDS = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              we,
   input  logic [7:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] words [N_WORDS];

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!pwr_rst_n)
            words[g] <= '0;
         else if (we && (32'(idx) == g))
            words[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_WORDS; k++)
         if (32'(idx) == k) rdata = words[k];
   end
endmodule

// File: rtl/hbr_imap_bank.sv
module hbr_imap_bank
   import hbr_pkg::*;
#(
   parameter int N_IMAP = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              sys_rst_n,
   input  logic              we,
   input  logic [7:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_IMAP-1:0] en
);
   logic [DATA_W-1:0] maps [N_IMAP];

   for (genvar g = 0; g < N_IMAP; g++) begin : g_map
      localparam logic [DATA_W-1:0] INIT = DATA_W'((32'h1F << 6) | (g << 2));
      always_ff @(posedge clk) begin
         if (!pwr_rst_n)
            maps[g] <= INIT;
         else if (!sys_rst_n)
            maps[g][DATA_W-1] <= 1'b0;
         else if (we && (32'(idx) == g))
            maps[g][DATA_W-1] <= wdata[DATA_W-1];
      end
      assign en[g] = maps[g][DATA_W-1];
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_IMAP; k++)
         if (32'(idx) == k) rdata = maps[k];
   end
endmodule

// File: rtl/hbr_rstctl.sv
module hbr_rstctl
   import hbr_pkg::*;
(
   input  logic        clk,
   input  logic        pwr_rst_n,
   input  logic        sys_rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   output logic [31:0] value,
   output logic        req
);
   logic        first_pending;
   logic [31:0] masked;
   logic [31:0] next_val;

   always_comb begin
      masked   = wdata & RC_KEEP;
      next_val = (value & ~(masked & RC_W1C) & ~RC_WDIR) | (masked & RC_WDIR);
   end

   always_ff @(posedge clk) begin
      if (!pwr_rst_n) begin
         value         <= RC_PWR_ON;
         first_pending <= 1'b0;
         req           <= 1'b0;
      end else if (!sys_rst_n) begin
         req <= 1'b0;
         if (first_pending) begin
            value         <= RC_PWR_ON;
            first_pending <= 1'b0;
         end
      end else begin
         req <= 1'b0;
         if (we) begin
            value <= next_val;
            if ((masked & RC_SW_PWR) != 0) begin
               req           <= 1'b1;
               first_pending <= 1'b1;
            end else if ((masked & RC_SW_XINT) != 0) begin
               req <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hbr_ctl_regs.sv
module hbr_ctl_regs
   import hbr_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter logic [15:0] XLT_BASE  = 16'h0200,
   parameter int          XLT_BYTES = 12,
   parameter logic [15:0] CTL_BASE  = 16'h2000,
   parameter int          CTL_BYTES = 48,
   parameter logic [15:0] IMAP_BASE = 16'h0C00,
   parameter int          N_IMAP    = 8,
   parameter logic [15:0] RST_BASE  = 16'hF020
) (
   input  logic              clk,
   input  logic              pwr_rst_n,
   input  logic              sys_rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [N_IMAP-1:0] irq_map_en,
   output logic              soft_rst_req
);
   localparam int N_XLT = XLT_BYTES / 4;
   localparam int N_CTL = CTL_BYTES / 4;

   if (DATA_W != 32) begin : g_bad_width
      $error("hbr_ctl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("hbr_ctl_regs: ADDR_W must be at least 16");
   end
   if (N_XLT < 1 || N_XLT > 64 || N_CTL < 1 || N_CTL > 64) begin : g_bad_win
      $error("hbr_ctl_regs: window sizes out of range");
   end
   if (N_IMAP < 1 || N_IMAP > 32) begin : g_bad_imap
      $error("hbr_ctl_regs: N_IMAP out of range");
   end

   hbr_region_e region;
   logic [7:0]  idx;
   logic [31:0] rd_xlt, rd_ctl, rd_imap, rd_rst;

   hbr_decode #(
      .XLT_BASE (XLT_BASE),  .XLT_BYTES (XLT_BYTES),
      .CTL_BASE (CTL_BASE),  .CTL_BYTES (CTL_BYTES),
      .IMAP_BASE(IMAP_BASE), .N_IMAP    (N_IMAP),
      .RST_BASE (RST_BASE)
   ) u_dec (
      .addr  (reg_addr[15:0]),
      .region(region),
      .idx   (idx)
   );

   hbr_word_bank #(.N_WORDS(N_XLT), .DATA_W(32)) u_xlt (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .we       (reg_wen && region == RG_XLT),
      .idx      (idx),
      .wdata    (reg_wdata),
      .rdata    (rd_xlt)
   );

   hbr_word_bank #(.N_WORDS(N_CTL), .DATA_W(32)) u_ctl (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .we       (reg_wen && region == RG_CTL),
      .idx      (idx),
      .wdata    (reg_wdata),
      .rdata    (rd_ctl)
   );

   hbr_imap_bank #(.N_IMAP(N_IMAP), .DATA_W(32)) u_imap (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .sys_rst_n(sys_rst_n),
      .we       (reg_wen && region == RG_IMAP),
      .idx      (idx),
      .wdata    (reg_wdata),
      .rdata    (rd_imap),
      .en       (irq_map_en)
   );

   hbr_rstctl u_rst (
      .clk      (clk),
      .pwr_rst_n(pwr_rst_n),
      .sys_rst_n(sys_rst_n),
      .we       (reg_wen && region == RG_RST),
      .wdata    (reg_wdata),
      .value    (rd_rst),
      .req      (soft_rst_req)
   );

   always_comb begin
      unique case (region)
         RG_XLT:  reg_rdata = rd_xlt;
         RG_CTL:  reg_rdata = rd_ctl;
         RG_IMAP: reg_rdata = rd_imap;
         RG_RST:  reg_rdata = rd_rst;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hbr_ctl_regs_chk.sv
module hbr_ctl_regs_chk #(
   parameter int ADDR_W = 32,
   parameter int N_IMAP = 8
) (
   input logic              clk,
   input logic              pwr_rst_n,
   input logic              sys_rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wen,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic [N_IMAP-1:0] irq_map_en,
   input logic              soft_rst_req
);
   logic to_rst;
   assign to_rst = reg_wen && (reg_addr[15:0] == 16'hF024);

   // R8
   req_single_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      soft_rst_req |=> !soft_rst_req);

   // R8
   req_cause_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n || !sys_rst_n)
      (to_rst && (reg_wdata[30] || reg_wdata[29])) |=> soft_rst_req);

   // R8
   req_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !(to_rst && (reg_wdata[30] || reg_wdata[29])) |=> !soft_rst_req);

   // R5
   en_clear_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !sys_rst_n |=> (irq_map_en == '0));

   // R4
   en_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n || !sys_rst_n)
      !reg_wen |=> $stable(irq_map_en));

   // R3
   imap_gap_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (reg_addr[15:6] == 10'b0000_1100_00 && !reg_addr[2]) |-> (reg_rdata == 32'd0));

   // R6
   rst_low_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (reg_addr[15:0] == 16'hF024) |-> (reg_rdata[26:0] == 27'd0));
endmodule

bind hbr_ctl_regs hbr_ctl_regs_chk #(.ADDR_W(ADDR_W), .N_IMAP(N_IMAP)) u_chk (
   .clk         (clk),
   .pwr_rst_n   (pwr_rst_n),
   .sys_rst_n   (sys_rst_n),
   .reg_addr    (reg_addr),
   .reg_wen     (reg_wen),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .irq_map_en  (irq_map_en),
   .soft_rst_req(soft_rst_req)
);

// File: tb/hbr_ctl_regs_test.sv
`timescale 1ns/1ps
module hbr_ctl_regs_test;
   logic        clk = 1'b0;
   logic        pwr_rst_n = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic [31:0] reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  irq_map_en;
   logic        soft_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   hbr_ctl_regs uut (
      .clk         (clk),
      .pwr_rst_n   (pwr_rst_n),
      .sys_rst_n   (sys_rst_n),
      .reg_addr    (reg_addr),
      .reg_wen     (reg_wen),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq_map_en  (irq_map_en),
      .soft_rst_req(soft_rst_req)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pwr_reset();
      @(negedge clk);
      pwr_rst_n = 1'b0; sys_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      pwr_rst_n = 1'b1; sys_rst_n = 1'b1;
   endtask

   task automatic sys_reset();
      @(negedge clk);
      sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      sys_rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      pwr_reset();
      check("R8 req idle after reset", {31'd0, soft_rst_req}, 32'd0);
      check("R5 enables clear after reset", {24'd0, irq_map_en}, 32'd0);
      rd(32'hF024, v); check("R9 reset word after power-on", v, 32'h8000_0000);
      for (int i = 0; i < 8; i++) begin
         rd(32'h0C04 + 8 * i, v);
         check("R5 map init value", v, 32'h7C0 | (i << 2));
      end
      rd(32'h0200, v); check("R11 xlt zero after power-on", v, 32'd0);
   endtask

   task automatic t_xlt();
      logic [31:0] v;
      for (int i = 0; i < 3; i++) wr(32'h0200 + 4 * i, 32'hA500_0000 + i);
      wr(32'h020C, 32'hDEAD_BEEF);
      for (int i = 0; i < 3; i++) begin
         rd(32'h0200 + 4 * i, v); check("R1 xlt readback", v, 32'hA500_0000 + i);
      end
      rd(32'h020C, v); check("R1 past xlt window", v, 32'd0);
      rd(32'h0001_0204, v); check("R10 high address bits ignored", v, 32'hA500_0001);
   endtask

   task automatic t_ctl();
      logic [31:0] v;
      for (int i = 0; i < 12; i++) wr(32'h2000 + 4 * i, 32'h1234_0000 ^ (i * 32'h0101_0101));
      wr(32'h2030, 32'hFFFF_FFFF);
      for (int i = 0; i < 12; i++) begin
         rd(32'h2000 + 4 * i, v); check("R2 ctl readback", v, 32'h1234_0000 ^ (i * 32'h0101_0101));
      end
      rd(32'h2030, v); check("R2 past ctl window", v, 32'd0);
   endtask

   task automatic t_imap();
      logic [31:0] v;
      for (int i = 0; i < 8; i += 2) wr(32'h0C04 + 8 * i, 32'hFFFF_FFFF);
      check("R4 enable outputs", {24'd0, irq_map_en}, 32'h55);
      rd(32'h0C14, v); check("R4 only bit 31 written", v, 32'h8000_07C0 | (2 << 2));
      rd(32'h0C0C, v); check("R4 odd map untouched", v, 32'h7C0 | (1 << 2));
      wr(32'h0C08, 32'h8000_0000);
      check("R3 bit2 clear write ignored", {24'd0, irq_map_en}, 32'h55);
      rd(32'h0C08, v); check("R3 bit2 clear reads zero", v, 32'd0);
      wr(32'h0C04, 32'h0000_0000);
      check("R4 enable cleared", {24'd0, irq_map_en}, 32'h54);
   endtask

   task automatic t_sysrst_keep();
      logic [31:0] v;
      sys_reset();
      check("R5 sys reset clears enables", {24'd0, irq_map_en}, 32'd0);
      rd(32'h0C24, v); check("R5 sys reset keeps low bits", v, 32'h7C0 | (4 << 2));
      rd(32'h0208, v); check("R11 xlt kept over sys reset", v, 32'hA500_0002);
      rd(32'h202C, v); check("R11 ctl kept over sys reset", v, 32'h1234_0000 ^ (11 * 32'h0101_0101));
   endtask

   task automatic t_rstctl();
      logic [31:0] v;
      rd(32'hF024, v); check("R9 no re-arm on later sys reset", v, 32'h8000_0000);
      wr(32'hF024, 32'h8000_0000);
      rd(32'hF024, v); check("R7 bit31 write-one-clear", v, 32'd0);
      wr(32'hF020, 32'h6000_0000);
      check("R6 lower half no request", {31'd0, soft_rst_req}, 32'd0);
      rd(32'hF020, v); check("R6 lower half reads zero", v, 32'd0);
      rd(32'hF024, v); check("R6 lower half write ignored", v, 32'd0);
      wr(32'hF024, 32'h2000_0000);
      check("R8 request after bit29 write", {31'd0, soft_rst_req}, 32'd1);
      @(negedge clk);
      check("R8 request lasts one cycle", {31'd0, soft_rst_req}, 32'd0);
      rd(32'hF024, v); check("R7 bit29 takes value", v, 32'h2000_0000);
      sys_reset();
      rd(32'hF024, v); check("R9 bit29 does not re-arm", v, 32'h2000_0000);
      wr(32'hF024, 32'h47FF_FFFF);
      check("R8 request after bit30 write", {31'd0, soft_rst_req}, 32'd1);
      rd(32'hF024, v); check("R6 R7 masked direct bits", v, 32'h4000_0000);
      @(negedge clk);
      check("R8 bit30 request one cycle", {31'd0, soft_rst_req}, 32'd0);
      wr(32'hF024, 32'h0000_0000);
      check("R8 zero write no request", {31'd0, soft_rst_req}, 32'd0);
      rd(32'hF024, v); check("R7 direct bits written zero", v, 32'd0);
      sys_reset();
      rd(32'hF024, v); check("R9 bit30 re-arms power-on status", v, 32'h8000_0000);
      sys_reset();
      rd(32'hF024, v); check("R9 second reset leaves word", v, 32'h8000_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(32'h0030, 32'hFFFF_FFFF);
      wr(32'h5000, 32'hFFFF_FFFF);
      wr(32'hF000, 32'hFFFF_FFFF);
      rd(32'h0030, v); check("R10 offset 0x0030 zero", v, 32'd0);
      rd(32'h5000, v); check("R10 offset 0x5000 zero", v, 32'd0);
      rd(32'hF000, v); check("R10 offset 0xF000 zero", v, 32'd0);
      rd(32'h0200, v); check("R10 neighbours untouched", v, 32'hA500_0000);
   endtask

   task automatic t_pwr_again();
      logic [31:0] v;
      pwr_reset();
      rd(32'h0204, v); check("R11 power-on clears xlt", v, 32'd0);
      rd(32'h2004, v); check("R11 power-on clears ctl", v, 32'd0);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_xlt();
      t_ctl();
      t_imap();
      t_sysrst_keep();
      t_rstctl();
      t_unmapped();
      t_pwr_again();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule